// File: doc/BRIEF.md
# Substitute-and-rotate stage fault flagger

This block watches one combined byte-substitution and row-rotation stage of an AES round. It takes the 128-bit state that enters the substitution and the 128-bit state that the datapath says leaves the rotation. Either state may have been corrupted by a defect or by a deliberate fault. For every byte it tests whether the two bytes obey the S-box relation. The test uses field arithmetic rather than a stored table, so it gives the same answer whether the datapath's S-box is a lookup table or gate logic.

The block produces sixteen error flags. Each flag sits at the position of the byte it judges in the rotated output state. A single alarm line is the OR of the sixteen flags. A mode input chooses between two checks: the forward pair (substitute, then rotate left), or the inverse pair (rotate right, then inverse-substitute) used in decryption.

Results are registered. They appear one clock edge after the edge at which a valid strobe samples the two states, and they hold until the next valid strobe.

Top module: `subshift_fault_flagger`

## Requirements
- R1: The state byte at row r, column c occupies bits [8*(r+4c)+7 : 8*(r+4c)] of both state ports. Flag bit r+4c of `byte_err` judges the output byte at row r, column c.
- R2: With `dec_mode`=0, every post state equal to a correct forward substitution followed by a left rotation of row r by r bytes gives all flags 0. This holds for all 256 byte values.
- R3: With `dec_mode`=1, every post state equal to a correct rotation right of row r by r bytes followed by inverse substitution gives all flags 0. This holds for all 256 byte values.
- R4: In forward mode, an input byte 0x00 paired with output 0x63 gives no flag. An input byte 0x00 paired with any other output value raises that byte's flag.
- R5: In forward mode, corrupting output byte (r,c) raises exactly flag r+4c. Corrupting input byte (r,j) raises exactly the flag of output position (r,(j-r) mod 4).
- R6: In inverse mode, corrupting output byte (r,c) raises exactly flag r+4c. Corrupting input byte (r,j) raises exactly the flag of output position (r,(j+r) mod 4).
- R7: `out_valid` equals `in_valid` delayed by one clock. `alarm` equals the OR of `byte_err`, and both are updated at the same edge.
- R8: While `in_valid` is 0, `byte_err` and `alarm` keep their values whatever the state inputs do.
- R9: While `rst_n` is low, `out_valid`, `byte_err` and `alarm` are 0 at every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Samples the mode and both states |
| dec_mode | input | 1 | 0 = forward pair, 1 = inverse pair |
| pre_state | input | 128 | State entering the stage |
| post_state | input | 128 | State produced by the stage |
| out_valid | output | 1 | Flags were refreshed at the last edge |
| byte_err | output | 16 | Per-byte error flags at output positions |
| alarm | output | 1 | OR of all flags |

## Verification
Every result is due one edge after the edge that samples `in_valid` high. The bench drives inputs on the falling edge, lets one rising edge pass, and reads `out_valid`, `byte_err` and `alarm` 1 ns later. The check for the valid strobe falling back to 0 waits one further rising edge. The hold tests drive new, bad states with the strobe low across several rising edges, and read the flags after each of those edges to show that nothing moved.

// File: rtl/subshift_chk_pkg.sv
package subshift_chk_pkg;

   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] AFF_CONST = 8'h63;
   localparam logic [BYTE_W-1:0] RED_POLY  = 8'h1B;

   // product in GF(2^8) modulo x^8+x^4+x^3+x+1
   function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] x,
                                                input logic [BYTE_W-1:0] y);
      logic [BYTE_W-1:0] acc;
      logic [BYTE_W-1:0] p;
      acc = '0;
      p   = x;
      for (int i = 0; i < BYTE_W; i++) begin
         if (y[i]) acc = acc ^ p;
         p = {p[BYTE_W-2:0], 1'b0} ^ (p[BYTE_W-1] ? RED_POLY : '0);
      end
      return acc;
   endfunction

   // undo the affine step: removes the constant, then applies the inverse bit matrix
   function automatic logic [BYTE_W-1:0] undo_affine(input logic [BYTE_W-1:0] s);
      logic [BYTE_W-1:0] t;
      t = s ^ AFF_CONST;
      return {t[1:0], t[7:2]} ^ {t[4:0], t[7:5]} ^ {t[6:0], t[7]};
   endfunction

endpackage

// File: rtl/sbox_pair_check.sv
module sbox_pair_check
   import subshift_chk_pkg::*;
#(
   parameter int W = BYTE_W
) (
   input  logic [W-1:0] fwd_in,
   input  logic [W-1:0] fwd_out,
   output logic         bad
);
   generate
      if (W != BYTE_W) begin : g_bad_width
         $error("sbox_pair_check: byte width must be 8");
      end
   endgenerate

   logic             in_zero;
   logic [W-1:0]     inv_guess;
   logic [W-1:0]     prod;

   always_comb begin
      in_zero   = ~|fwd_in;
      inv_guess = undo_affine(fwd_out);
      prod      = gf_mul(fwd_in, inv_guess);
      if (in_zero) bad = (fwd_out != AFF_CONST);
      else         bad = (prod != 8'h01);
   end
endmodule

// File: rtl/shift_route.sv
module shift_route #(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   parameter int W    = 8,
   localparam int NB  = ROWS * COLS,
   localparam int SW  = NB * W
) (
   input  logic          dec_mode,
   input  logic [SW-1:0] pre_state,
   input  logic [SW-1:0] post_state,
   output logic [SW-1:0] fwd_in_bus,
   output logic [SW-1:0] fwd_out_bus
);
   // fwd_in_bus holds the S-box input side, fwd_out_bus the S-box output side,
   // both indexed by the output position of the row rotation
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam int K     = r + ROWS * c;
         localparam int SRC_E = r + ROWS * ((c + r) % COLS);
         localparam int SRC_D = r + ROWS * ((c + COLS - (r % COLS)) % COLS);
         always_comb begin
            if (dec_mode) begin
               fwd_in_bus [K*W +: W] = post_state[K*W +: W];
               fwd_out_bus[K*W +: W] = pre_state [SRC_D*W +: W];
            end else begin
               fwd_in_bus [K*W +: W] = pre_state [SRC_E*W +: W];
               fwd_out_bus[K*W +: W] = post_state[K*W +: W];
            end
         end
      end
   end
endmodule

// File: rtl/subshift_fault_flagger.sv
module subshift_fault_flagger
   import subshift_chk_pkg::*;
#(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   localparam int NB  = ROWS * COLS,
   localparam int SW  = NB * BYTE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          dec_mode,
   input  logic [SW-1:0] pre_state,
   input  logic [SW-1:0] post_state,
   output logic          out_valid,
   output logic [NB-1:0] byte_err,
   output logic          alarm
);
   generate
      if (ROWS < 1 || COLS < 1 || ROWS > COLS) begin : g_bad_shape
         $error("subshift_fault_flagger: need 1 <= ROWS <= COLS");
      end
   endgenerate

   logic [SW-1:0] fwd_in_bus;
   logic [SW-1:0] fwd_out_bus;
   logic [NB-1:0] flag_next;

   shift_route #(.ROWS(ROWS), .COLS(COLS), .W(BYTE_W)) i_route (
      .dec_mode   (dec_mode),
      .pre_state  (pre_state),
      .post_state (post_state),
      .fwd_in_bus (fwd_in_bus),
      .fwd_out_bus(fwd_out_bus)
   );

   for (genvar k = 0; k < NB; k++) begin : g_lane
      sbox_pair_check #(.W(BYTE_W)) i_pair (
         .fwd_in (fwd_in_bus [k*BYTE_W +: BYTE_W]),
         .fwd_out(fwd_out_bus[k*BYTE_W +: BYTE_W]),
         .bad    (flag_next[k])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         byte_err  <= '0;
         alarm     <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            byte_err <= flag_next;
            alarm    <= |flag_next;
         end
      end
   end
endmodule

// File: rtl/subshift_fault_checker.sv
module subshift_fault_checker #(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   localparam int NB  = ROWS * COLS,
   localparam int SW  = NB * 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          dec_mode,
   input logic [SW-1:0] pre_state,
   input logic [SW-1:0] post_state,
   input logic          out_valid,
   input logic [NB-1:0] byte_err,
   input logic          alarm
);
   // R7
   valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R7
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R7
   alarm_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm == (|byte_err));
   // R8
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(byte_err) && $stable(alarm)));
   // R4
   zero_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dec_mode && pre_state == '0 && post_state == {NB{8'h63}})
      |=> !alarm);
   // R9
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && byte_err == '0 && !alarm));
endmodule

bind subshift_fault_flagger subshift_fault_checker #(.ROWS(ROWS), .COLS(COLS)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .dec_mode  (dec_mode),
   .pre_state (pre_state),
   .post_state(post_state),
   .out_valid (out_valid),
   .byte_err  (byte_err),
   .alarm     (alarm)
);

// File: tb/test_subshift_fault_flagger.sv
`timescale 1ns/1ps
module test_subshift_fault_flagger;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         dec_mode = 1'b0;
   logic [127:0] pre_state = '0;
   logic [127:0] post_state = '0;
   logic         out_valid;
   logic [15:0]  byte_err;
   logic         alarm;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] sb  [256];
   logic [7:0] isb [256];

   always #2.5 clk = ~clk;

   subshift_fault_flagger i_subshift_fault_flagger (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dec_mode(dec_mode),
      .pre_state(pre_state), .post_state(post_state),
      .out_valid(out_valid), .byte_err(byte_err), .alarm(alarm)
   );

   function automatic logic [7:0] tb_xtime(input logic [7:0] v);
      return v[7] ? ((v << 1) ^ 8'h1B) : (v << 1);
   endfunction

   function automatic logic [7:0] tb_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] r = 8'h00;
      logic [7:0] x = a;
      logic [7:0] y = b;
      while (y != 0) begin
         if (y[0]) r ^= x;
         x = tb_xtime(x);
         y = y >> 1;
      end
      return r;
   endfunction

   function automatic logic [7:0] rol(input logic [7:0] v, input int n);
      return (v << n) | (v >> (8 - n));
   endfunction

   function automatic int pos(input int r, input int c);
      return r + 4 * c;
   endfunction

   function automatic logic [127:0] fwd_state(input logic [127:0] p);
      logic [127:0] q;
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 4; c++)
            q[8*pos(r,c) +: 8] = sb[p[8*pos(r,(c+r)%4) +: 8]];
      return q;
   endfunction

   function automatic logic [127:0] inv_state(input logic [127:0] p);
      logic [127:0] q;
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 4; c++)
            q[8*pos(r,c) +: 8] = isb[p[8*pos(r,(c+4-r)%4) +: 8]];
      return q;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input logic m, input logic [127:0] p, input logic [127:0] q);
      @(negedge clk);
      in_valid = 1'b1; dec_mode = m; pre_state = p; post_state = q;
      @(posedge clk); #1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_flags(input string req, input logic [15:0] exp);
      check({req, " flags"}, {16'h0, byte_err}, {16'h0, exp});
      check({req, " alarm"}, {31'h0, alarm}, {31'h0, |exp});
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   task automatic t_reset();
      repeat (3) @(posedge clk);
      #1;
      check("R9 valid", {31'h0, out_valid}, 32'h0);
      check("R9 flags", {16'h0, byte_err}, 32'h0);
      check("R9 alarm", {31'h0, alarm}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_fwd_clean();
      for (int i = 0; i < 16; i++) begin
         logic [127:0] p;
         for (int k = 0; k < 16; k++) p[8*k +: 8] = 8'(16*i + k);
         apply(1'b0, p, fwd_state(p));
         expect_flags("R2 fwd clean", 16'h0);
      end
      apply(1'b0, 128'h0f0e0d0c0b0a09080706050403020100, fwd_state(128'h0f0e0d0c0b0a09080706050403020100));
      expect_flags("R1 fwd layout", 16'h0);
   endtask

   task automatic t_inv_clean();
      for (int i = 0; i < 16; i++) begin
         logic [127:0] p;
         for (int k = 0; k < 16; k++) p[8*k +: 8] = 8'(16*i + k);
         apply(1'b1, p, inv_state(p));
         expect_flags("R3 inv clean", 16'h0);
      end
   endtask

   task automatic t_zero();
      logic [127:0] q = {16{8'h63}};
      apply(1'b0, '0, q);
      expect_flags("R4 zero pair", 16'h0);
      q[8*pos(2,1) +: 8] = 8'h62;
      apply(1'b0, '0, q);
      expect_flags("R4 zero wrong", 16'h1 << pos(2,1));
   endtask

   task automatic t_fwd_fault();
      for (int t = 0; t < 24; t++) begin
         logic [127:0] p = rnd128();
         logic [127:0] q = fwd_state(p);
         int r = $urandom_range(0, 3);
         int c = $urandom_range(0, 3);
         logic [7:0] m = 8'($urandom_range(1, 255));
         q[8*pos(r,c) +: 8] ^= m;
         apply(1'b0, p, q);
         expect_flags("R5 fwd out fault", 16'h1 << pos(r,c));
      end
      for (int t = 0; t < 24; t++) begin
         logic [127:0] p = rnd128();
         logic [127:0] q = fwd_state(p);
         int r = $urandom_range(0, 3);
         int j = $urandom_range(0, 3);
         logic [7:0] m = 8'($urandom_range(1, 255));
         p[8*pos(r,j) +: 8] ^= m;
         apply(1'b0, p, q);
         expect_flags("R5 fwd in fault", 16'h1 << pos(r, (j + 4 - r) % 4));
      end
   endtask

   task automatic t_inv_fault();
      for (int t = 0; t < 24; t++) begin
         logic [127:0] p = rnd128();
         logic [127:0] q = inv_state(p);
         int r = $urandom_range(0, 3);
         int c = $urandom_range(0, 3);
         logic [7:0] m = 8'($urandom_range(1, 255));
         q[8*pos(r,c) +: 8] ^= m;
         apply(1'b1, p, q);
         expect_flags("R6 inv out fault", 16'h1 << pos(r,c));
      end
      for (int t = 0; t < 24; t++) begin
         logic [127:0] p = rnd128();
         logic [127:0] q = inv_state(p);
         int r = $urandom_range(0, 3);
         int j = $urandom_range(0, 3);
         logic [7:0] m = 8'($urandom_range(1, 255));
         p[8*pos(r,j) +: 8] ^= m;
         apply(1'b1, p, q);
         expect_flags("R6 inv in fault", 16'h1 << pos(r, (j + r) % 4));
      end
   endtask

   task automatic t_valid_alarm();
      logic [127:0] p = rnd128();
      logic [127:0] q = fwd_state(p);
      q[8*pos(0,0) +: 8] ^= 8'h01;
      q[8*pos(3,3) +: 8] ^= 8'h80;
      @(negedge clk);
      in_valid = 1'b1; dec_mode = 1'b0; pre_state = p; post_state = q;
      @(posedge clk); #1;
      check("R7 valid high", {31'h0, out_valid}, 32'h1);
      expect_flags("R7 two faults", 16'h8001);
      @(negedge clk); in_valid = 1'b0;
      @(posedge clk); #1;
      check("R7 valid low", {31'h0, out_valid}, 32'h0);
   endtask

   task automatic t_hold();
      logic [127:0] p = rnd128();
      logic [127:0] q = fwd_state(p);
      q[8*pos(1,2) +: 8] ^= 8'h5A;
      apply(1'b0, p, q);
      expect_flags("R8 setup", 16'h1 << pos(1,2));
      for (int t = 0; t < 4; t++) begin
         @(negedge clk);
         pre_state = rnd128(); post_state = rnd128(); dec_mode = t[0];
         @(posedge clk); #1;
         expect_flags("R8 hold bad data", 16'h1 << pos(1,2));
      end
      @(negedge clk);
      pre_state = p; post_state = fwd_state(p);
      @(posedge clk); #1;
      expect_flags("R8 hold clean data", 16'h1 << pos(1,2));
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      for (int v = 0; v < 256; v++) begin
         logic [7:0] iv = 8'h00;
         logic [7:0] s;
         for (int j = 1; j < 256; j++)
            if (v != 0 && tb_mul(8'(v), 8'(j)) == 8'h01) iv = 8'(j);
         s = iv ^ rol(iv,1) ^ rol(iv,2) ^ rol(iv,3) ^ rol(iv,4) ^ 8'h63;
         sb[v] = s;
         isb[s] = 8'(v);
      end
      t_reset();
      t_fwd_clean();
      t_inv_clean();
      t_zero();
      t_fwd_fault();
      t_inv_fault();
      t_valid_alarm();
      t_hold();
      finish_run();
   end

   initial begin
      #(5.0 * 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end
endmodule